// File: doc/BRIEF.md
# Coherent Device Attribute Table Read Responder

This block serves table-read requests that reach a switch upstream port through a dword-wide data-object mailbox. A request carries an object length in dwords and an entry handle. If the request is well formed, the block streams back a three-dword response header and then the dwords of the requested table entry, one dword per accepted beat. The header reports the handle of the entry that follows, so software can walk the whole table by chaining handles until it sees the end marker.

The table is not stored. It is generated on the fly from a presence vector with one bit per device/function slot on the secondary bus. Entry 0 describes switch-internal latency and entry 1 describes bandwidth. Each entry has one record per present downstream port, and each record pairs the upstream port with that port's number. When no port is present, the table has no entries. Every request is then dropped, and a later request tries again against the presence vector as it stands at that time.

Top module: `cdat_table_responder`

## Requirements
- R1: A request whose object length `reqLenDw` is below 3 dwords produces no response. A length of exactly 3 is accepted.
- R2: A request whose handle is 2 or greater produces no response. This includes 16'hFFFF.
- R3: When no bit of `portPresent` is set, every request is dropped with no response. Once a port is present, the next request is answered.
- R4: Response dword 0 is {8'h00, 8'h02, 16'h1E98}. Dword 1 holds the response length in dwords in bits [17:0], with the upper bits zero. That length is 7 + 2*N, where N is the number of set presence bits.
- R5: Response dword 2 holds the next handle in bits [31:16], the table type 8'h00 in [15:8] and the response code 8'h00 in [7:0]. The next handle is 1 for a request of handle 0 and 16'hFFFF for a request of handle 1.
- R6: Dword 3 holds the structure length in bytes, 16 + 8*N, in bits [31:16], zero in [15:8] and structure type 8'h09 in [7:0]. Dword 4 holds the data type in [7:0]: 0 for latency (handle 0) and 3 for bandwidth (handle 1). Dwords 5 and 6 hold the 64-bit base unit, low half first: 10000 for latency and 1024 for bandwidth.
- R7: Two dwords per present port follow dword 6, with ports in ascending slot index. The first dword is {slot index[31:16], 16'h0100}. The second is {16'h0000, value}, where the value is 15 for latency and 16 for bandwidth.
- R8: `rspValid` is low after reset. A dword moves on each cycle with `rspValid` and `rspReady` both high. `rspData` holds while `rspReady` is low. `rspLast` marks only the final dword, and `rspValid` falls after that dword is taken.
- R9: The presence vector is sampled when a request is accepted. Changes to it during a response do not alter that response.
- R10: A request that arrives while a response is in progress is ignored. No extra response follows.
- R11: A cycle with `abort` high ends any response in progress, so `rspValid` is low in the next cycle. The next accepted request starts again at dword 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| portPresent | input | DEVFN_COUNT | One bit per secondary-bus slot holding a downstream port |
| reqValid | input | 1 | Request strobe, taken when idle |
| reqLenDw | input | 18 | Request object length in dwords |
| reqHandle | input | 16 | Requested entry handle |
| abort | input | 1 | Drop the response in progress |
| rspValid | output | 1 | Response dword valid |
| rspReady | input | 1 | Consumer accepts the dword |
| rspData | output | 32 | Response dword |
| rspLast | output | 1 | Final dword of the response |

## Verification
Most internal faults show up within one response at the data port. A slip in the word counter moves every following dword or cuts the length short. A slip in the slot walker puts the wrong port number in the first record that follows it. An accept decision that is wrong turns a dropped request into a stream, or the reverse, one cycle after the strobe. The bench sweeps every presence pattern of an 8-slot build with both handles and mixes stall cycles into the ready signal. Under that sweep, any such fault changes a compared dword or the length of a stream.

// File: rtl/cdat_resp_pkg.sv
package cdat_resp_pkg;

  typedef struct packed {
    logic capture;
    logic advance;
    logic clear;
  } dpCtrl_t;

  localparam logic [15:0] VENDOR_ID    = 16'h1E98;
  localparam logic [7:0]  OBJ_TYPE     = 8'h02;
  localparam logic [7:0]  RSP_CODE     = 8'h00;
  localparam logic [7:0]  TABLE_TYPE   = 8'h00;
  localparam logic [15:0] END_HANDLE   = 16'hFFFF;
  localparam logic [7:0]  STRUCT_TYPE  = 8'h09;
  localparam logic [7:0]  DTYPE_LAT    = 8'h00;
  localparam logic [7:0]  DTYPE_BW     = 8'h03;
  localparam logic [15:0] USP_ID       = 16'h0100;
  localparam logic [63:0] LAT_UNIT     = 64'd10000;
  localparam logic [63:0] BW_UNIT      = 64'd1024;
  localparam logic [15:0] LAT_VAL      = 16'd15;
  localparam logic [15:0] BW_VAL       = 16'd16;

  localparam int REQ_DW        = 3;
  localparam int HDR_DW        = 3;
  localparam int STRUCT_HDR_DW = 4;
  localparam int REC_DW        = 2;
  localparam int ENTRY_COUNT   = 2;

endpackage

// File: rtl/cdat_resp_ctrl.sv
module cdat_resp_ctrl
  import cdat_resp_pkg::*;
#(
  parameter int LEN_W    = 18,
  parameter int HANDLE_W = 16,
  parameter int CNT_W    = 9
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic [LEN_W-1:0]    reqLenDw,
  input  logic [HANDLE_W-1:0] reqHandle,
  input  logic [CNT_W-1:0]    liveCount,
  input  logic                abort,
  input  logic                rspReady,
  input  logic                lastWord,
  output logic                rspValid,
  output logic                rspLast,
  output dpCtrl_t             ctl
);

  typedef enum logic {ST_IDLE, ST_SEND} state_t;

  state_t state, stateNext;
  logic   lenOk, handleOk, tableBuilt, accept, beat;

  assign lenOk      = reqLenDw >= LEN_W'(REQ_DW);
  assign handleOk   = reqHandle < HANDLE_W'(ENTRY_COUNT);
  assign tableBuilt = liveCount != '0;
  assign accept     = (state == ST_IDLE) && reqValid && !abort && lenOk && handleOk && tableBuilt;
  assign beat       = (state == ST_SEND) && rspReady && !abort;

  always_comb begin
    ctl.capture = accept;
    ctl.advance = beat;
    ctl.clear   = abort;
  end

  always_comb begin
    stateNext = state;
    if (abort)                  stateNext = ST_IDLE;
    else if (accept)            stateNext = ST_SEND;
    else if (beat && lastWord)  stateNext = ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign rspValid = (state == ST_SEND);
  assign rspLast  = (state == ST_SEND) && lastWord;

endmodule

// File: rtl/cdat_resp_dp.sv
module cdat_resp_dp
  import cdat_resp_pkg::*;
#(
  parameter int DEVFN_COUNT = 256,
  parameter int HANDLE_W    = 16,
  parameter int DATA_W      = 32
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  dpCtrl_t                      ctl,
  input  logic [DEVFN_COUNT-1:0]       portPresent,
  input  logic [HANDLE_W-1:0]          reqHandle,
  output logic [$clog2(DEVFN_COUNT+1)-1:0] liveCount,
  output logic                         lastWord,
  output logic [DATA_W-1:0]            rspData
);

  localparam int IDX_W    = $clog2(DEVFN_COUNT);
  localparam int CNT_W    = $clog2(DEVFN_COUNT + 1);
  localparam int WORD_W   = CNT_W + 3;
  localparam int FIXED_DW = HDR_DW + STRUCT_HDR_DW;

  function automatic logic [CNT_W-1:0] countPorts(input logic [DEVFN_COUNT-1:0] vec);
    logic [CNT_W-1:0] c;
    c = '0;
    for (int i = 0; i < DEVFN_COUNT; i++) c = c + CNT_W'(vec[i]);
    return c;
  endfunction

  function automatic logic [IDX_W-1:0] firstFrom(input logic [DEVFN_COUNT-1:0] vec,
                                                 input logic [IDX_W:0] start);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = DEVFN_COUNT - 1; i >= 0; i--)
      if (vec[i] && (i >= int'(start))) r = IDX_W'(i);
    return r;
  endfunction

  logic [DEVFN_COUNT-1:0] snap;
  logic                   entrySel;
  logic [CNT_W-1:0]       countQ;
  logic [WORD_W-1:0]      wordIdx;
  logic [IDX_W-1:0]       devPtr;

  logic [WORD_W-1:0]      lenDw;
  logic [WORD_W-1:0]      relIdx;
  logic                   inRecords, secondHalf;
  logic [15:0]            structBytes, nextHandle, recVal;
  logic [63:0]            baseUnit;
  logic [7:0]             dataType;

  assign liveCount   = countPorts(portPresent);
  assign lenDw       = WORD_W'(FIXED_DW) + (WORD_W'(countQ) << 1);
  assign lastWord    = (wordIdx == lenDw - WORD_W'(1));
  assign relIdx      = wordIdx - WORD_W'(FIXED_DW);
  assign inRecords   = wordIdx >= WORD_W'(FIXED_DW);
  assign secondHalf  = relIdx[0];
  assign structBytes = 16'(STRUCT_HDR_DW * 4) + (16'(countQ) << 3);
  assign nextHandle  = entrySel ? END_HANDLE : 16'd1;
  assign baseUnit    = entrySel ? BW_UNIT : LAT_UNIT;
  assign dataType    = entrySel ? DTYPE_BW : DTYPE_LAT;
  assign recVal      = entrySel ? BW_VAL : LAT_VAL;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      snap     <= '0;
      entrySel <= 1'b0;
      countQ   <= '0;
      wordIdx  <= '0;
      devPtr   <= '0;
    end else if (ctl.clear) begin
      wordIdx  <= '0;
    end else if (ctl.capture) begin
      snap     <= portPresent;
      entrySel <= reqHandle[0];
      countQ   <= liveCount;
      wordIdx  <= '0;
      devPtr   <= firstFrom(portPresent, '0);
    end else if (ctl.advance) begin
      wordIdx <= wordIdx + WORD_W'(1);
      if (inRecords && secondHalf)
        devPtr <= firstFrom(snap, {1'b0, devPtr} + (IDX_W+1)'(1));
    end
  end

  always_comb begin
    rspData = '0;
    if (inRecords) begin
      if (secondHalf) rspData = {16'h0000, recVal};
      else            rspData = {16'(devPtr), USP_ID};
    end else begin
      case (wordIdx[2:0])
        3'd0:    rspData = {8'h00, OBJ_TYPE, VENDOR_ID};
        3'd1:    rspData = DATA_W'(lenDw);
        3'd2:    rspData = {nextHandle, TABLE_TYPE, RSP_CODE};
        3'd3:    rspData = {structBytes, 8'h00, STRUCT_TYPE};
        3'd4:    rspData = {24'h000000, dataType};
        3'd5:    rspData = baseUnit[31:0];
        3'd6:    rspData = baseUnit[63:32];
        default: rspData = '0;
      endcase
    end
  end

endmodule

// File: rtl/cdat_table_responder.sv
module cdat_table_responder
  import cdat_resp_pkg::*;
#(
  parameter int DEVFN_COUNT = 256,
  parameter int LEN_W       = 18,
  parameter int HANDLE_W    = 16,
  parameter int DATA_W      = 32
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [DEVFN_COUNT-1:0] portPresent,
  input  logic                   reqValid,
  input  logic [LEN_W-1:0]       reqLenDw,
  input  logic [HANDLE_W-1:0]    reqHandle,
  input  logic                   abort,
  output logic                   rspValid,
  input  logic                   rspReady,
  output logic [DATA_W-1:0]      rspData,
  output logic                   rspLast
);

  localparam int CNT_W = $clog2(DEVFN_COUNT + 1);

  dpCtrl_t          ctl;
  logic [CNT_W-1:0] liveCount;
  logic             lastWord;

  cdat_resp_ctrl #(.LEN_W(LEN_W), .HANDLE_W(HANDLE_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqLenDw(reqLenDw),
    .reqHandle(reqHandle), .liveCount(liveCount), .abort(abort),
    .rspReady(rspReady), .lastWord(lastWord), .rspValid(rspValid),
    .rspLast(rspLast), .ctl(ctl)
  );

  cdat_resp_dp #(.DEVFN_COUNT(DEVFN_COUNT), .HANDLE_W(HANDLE_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .portPresent(portPresent),
    .reqHandle(reqHandle), .liveCount(liveCount), .lastWord(lastWord),
    .rspData(rspData)
  );

endmodule

// File: rtl/cdat_table_responder_chk.sv
module cdat_table_responder_chk #(
  parameter int DEVFN_COUNT = 256,
  parameter int LEN_W       = 18,
  parameter int HANDLE_W    = 16,
  parameter int DATA_W      = 32
) (
  input logic                   clk,
  input logic                   rstN,
  input logic [DEVFN_COUNT-1:0] portPresent,
  input logic                   reqValid,
  input logic [LEN_W-1:0]       reqLenDw,
  input logic [HANDLE_W-1:0]    reqHandle,
  input logic                   abort,
  input logic                   rspValid,
  input logic                   rspReady,
  input logic [DATA_W-1:0]      rspData,
  input logic                   rspLast
);

  // R1
  short_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !rspValid && reqLenDw < LEN_W'(3)) |=> !rspValid);

  // R2
  bad_handle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !rspValid && reqHandle >= HANDLE_W'(2)) |=> !rspValid);

  // R3
  empty_table_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !rspValid && portPresent == '0) |=> !rspValid);

  // R4
  first_word_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rspValid) |-> rspData == {8'h00, 8'h02, 16'h1E98});

  // R8
  hold_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspReady && !abort) |=> (rspValid && $stable(rspData)));

  // R8
  last_in_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspLast |-> rspValid);

  // R8
  end_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspReady && rspLast && !abort) |=> !rspValid);

  // R11
  abort_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    abort |=> !rspValid);

endmodule

bind cdat_table_responder cdat_table_responder_chk #(
  .DEVFN_COUNT(DEVFN_COUNT), .LEN_W(LEN_W), .HANDLE_W(HANDLE_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rstN(rstN), .portPresent(portPresent), .reqValid(reqValid),
  .reqLenDw(reqLenDw), .reqHandle(reqHandle), .abort(abort),
  .rspValid(rspValid), .rspReady(rspReady), .rspData(rspData), .rspLast(rspLast)
);

// File: tb/cdat_table_responder_bench.sv
module cdat_table_responder_bench;

  localparam int NSLOT = 8;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [NSLOT-1:0] portPresent = '0;
  logic             reqValid = 1'b0;
  logic [17:0]      reqLenDw = '0;
  logic [15:0]      reqHandle = '0;
  logic             abort = 1'b0;
  logic             rspValid;
  logic             rspReady = 1'b0;
  logic [31:0]      rspData;
  logic             rspLast;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  cdat_table_responder #(.DEVFN_COUNT(NSLOT)) u_cdat_table_responder (
    .clk(clk), .rstN(rstN), .portPresent(portPresent), .reqValid(reqValid),
    .reqLenDw(reqLenDw), .reqHandle(reqHandle), .abort(abort),
    .rspValid(rspValid), .rspReady(rspReady), .rspData(rspData), .rspLast(rspLast)
  );

  function automatic int popc(input logic [NSLOT-1:0] v);
    int n = 0;
    for (int i = 0; i < NSLOT; i++) n += int'(v[i]);
    return n;
  endfunction

  function automatic logic [31:0] expWord(input logic [NSLOT-1:0] v, input int h, input int w);
    int n, k, seen, slot;
    n = popc(v);
    case (w)
      0: return {8'h00, 8'h02, 16'h1E98};
      1: return 32'(7 + 2 * n);
      2: return {(h == 0) ? 16'd1 : 16'hFFFF, 16'h0000};
      3: return {16'(16 + 8 * n), 8'h00, 8'h09};
      4: return (h == 0) ? 32'd0 : 32'd3;
      5: return (h == 0) ? 32'd10000 : 32'd1024;
      6: return 32'd0;
      default: begin
        k = (w - 7) / 2;
        seen = 0;
        slot = 0;
        for (int i = 0; i < NSLOT; i++)
          if (v[i]) begin
            if (seen == k) slot = i;
            seen++;
          end
        if (((w - 7) % 2) == 0) return {16'(slot), 16'h0100};
        return {16'h0000, (h == 0) ? 16'd15 : 16'd16};
      end
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sendReq(input logic [NSLOT-1:0] v, input logic [15:0] h, input logic [17:0] len);
    @(negedge clk);
    portPresent = v;
    reqHandle = h;
    reqLenDw = len;
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic expectSilence(input string req);
    for (int i = 0; i < 4; i++) begin
      #1;
      check(rspValid == 1'b0, req, 32'(rspValid), 32'd0);
      @(negedge clk);
    end
  endtask

  // Collects a full response; optional mid-stream topology change (R9) or stray request (R10).
  task automatic collect(input logic [NSLOT-1:0] v, input int h, input string req,
                         input bit doSwap, input logic [NSLOT-1:0] swapVec, input bit doInject);
    int total, got, guard;
    bit r;
    total = 7 + 2 * popc(v);
    got = 0;
    guard = 0;
    while (got < total && guard < 2000) begin
      r = ((cyc % 4) != 3);
      rspReady = r;
      if (doSwap && got == 2) portPresent = swapVec;
      reqValid = (doInject && got == 3);
      reqHandle = 16'd1;
      #1;
      if (!rspValid) begin
        check(1'b0, req, 32'(got), 32'(total));
        got = total;
      end else if (r) begin
        check(rspData == expWord(v, h, got), req, rspData, expWord(v, h, got));
        check(rspLast == (got == total - 1), "R8", 32'(rspLast), 32'(got == total - 1));
        got++;
      end
      @(negedge clk);
      guard++;
    end
    reqValid = 1'b0;
    rspReady = 1'b0;
    #1;
    check(rspValid == 1'b0, "R8", 32'(rspValid), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(rspValid == 1'b0, "R8", 32'(rspValid), 32'd0);
    rstN = 1'b1;

    // R4 R5 R6 R7: every presence pattern, both entries
    for (int v = 1; v < 256; v++)
      for (int h = 0; h < 2; h++) begin
        sendReq(8'(v), 16'(h), 18'd3);
        collect(8'(v), h, (h == 0) ? "R4/R6/R7 latency" : "R5/R6/R7 bandwidth", 1'b0, '0, 1'b0);
      end

    // R1: short request lengths
    for (int len = 0; len < 3; len++) begin
      sendReq(8'hA5, 16'd0, 18'(len));
      expectSilence("R1");
    end
    sendReq(8'hA5, 16'd0, 18'd40);
    collect(8'hA5, 0, "R1 long length accepted", 1'b0, '0, 1'b0);

    // R2: out-of-range handles
    sendReq(8'h3C, 16'd2, 18'd3);
    expectSilence("R2");
    sendReq(8'h3C, 16'hFFFF, 18'd3);
    expectSilence("R2");

    // R3: empty table, then retry after a port appears
    sendReq(8'h00, 16'd0, 18'd3);
    expectSilence("R3");
    sendReq(8'h00, 16'd1, 18'd3);
    expectSilence("R3");
    sendReq(8'h80, 16'd1, 18'd3);
    collect(8'h80, 1, "R3 retry", 1'b0, '0, 1'b0);

    // R9: presence change during response
    sendReq(8'h0F, 16'd0, 18'd3);
    collect(8'h0F, 0, "R9", 1'b1, 8'hF0, 1'b0);

    // R10: request during response ignored
    sendReq(8'h81, 16'd0, 18'd3);
    collect(8'h81, 0, "R10", 1'b0, '0, 1'b1);
    expectSilence("R10");

    // R11: abort mid-stream, then restart at dword 0
    sendReq(8'hFF, 16'd1, 18'd3);
    rspReady = 1'b1;
    repeat (4) @(negedge clk);
    abort = 1'b1;
    rspReady = 1'b0;
    @(negedge clk);
    abort = 1'b0;
    #1;
    check(rspValid == 1'b0, "R11", 32'(rspValid), 32'd0);
    expectSilence("R11");
    sendReq(8'hFF, 16'd1, 18'd3);
    collect(8'hFF, 1, "R11 restart", 1'b0, '0, 1'b0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule